// File: doc/BRIEF.md
# Resource Descriptor Stream Walker

This block walks a byte stream of plug-and-play resource descriptors one item at a time. Every item begins with a tag byte. The top bit of the tag selects one of two header layouts. A small item packs a 4-bit item number and a 3-bit payload length into the tag itself. A large item gives a 7-bit item number in the tag, and a little-endian length field follows it. For each item the walker raises a one-cycle header event carrying the format, the item number and the payload length. It then forwards exactly that many payload bytes on a separate strobed byte output.

The walk ends at the small end item (number 0xF). The walker then asserts `done` and accepts and discards further input until a `start` pulse re-arms it. The walker does not interpret payload contents and does not verify checksums. When an item number falls in a reserved range, the walker still skips the item by its length and forwards its payload. It also sets a sticky `reserved_seen` flag.

Top module: `rdesc_walker`

## Requirements
- R1: After reset, `done`, `hdr_valid`, `pay_valid` and `reserved_seen` are 0 and `in_ready` is 1.
- R2: A tag byte with bit 7 = 0 is a small item: bits [6:3] are the item number and bits [2:0] are the payload length. The cycle after the tag is accepted, `hdr_valid` pulses with `hdr_large`=0, `hdr_item`={3'b0,bits[6:3]} and `hdr_len`=bits[2:0].
- R3: A tag byte with bit 7 = 1 is a large item with item number bits [6:0]. The next two accepted bytes are the length, low byte first. No header is emitted until the high length byte is accepted. The cycle after that byte, `hdr_valid` pulses with `hdr_large`=1 and `hdr_len`={high,low}.
- R4: Each payload byte accepted is shown on `pay_data` with `pay_valid`=1 in the following cycle. Exactly `hdr_len` bytes are treated as payload, and the byte after them is decoded as a tag.
- R5: An item of length 0, small or large, produces a header event and no payload bytes. The next accepted byte is decoded as a tag.
- R6: The small end item (number 0xF) produces a header event. In the same cycle `done` rises, and no payload is forwarded for it.
- R7: While `done` is 1, accepted bytes produce no `hdr_valid` and no `pay_valid`, and `done` stays 1.
- R8: A `start` pulse returns the walker to expecting a tag and clears `done` and `reserved_seen`. During the `start` cycle `in_ready` is 0.
- R9: Small item numbers 0xA to 0xD and large item numbers 0x07 to 0x7F set `reserved_seen` in the header cycle. The flag stays set until `start`, and such items still forward their payload by length. Other item numbers leave the flag unchanged.
- R10: Cycles with `in_valid`=0 change no state. A walk that stalls in the middle of a payload resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Restart pulse |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| hdr_valid | output | 1 | One-cycle item header event |
| hdr_large | output | 1 | Item uses the large format |
| hdr_item | output | 7 | Item number |
| hdr_len | output | 16 | Payload length in bytes |
| pay_valid | output | 1 | Payload byte strobe |
| pay_data | output | 8 | Payload byte |
| done | output | 1 | End item reached |
| reserved_seen | output | 1 | Sticky reserved-item flag |

## Verification
The bench targets the points where the walker changes format. In a large item, a walker that emitted its header early or swapped the length bytes would report a wrong `hdr_len`. A 256-byte payload makes a design that ignored the high byte fall back into tag decoding far too soon. Zero-length items of both formats, each followed at once by a tag, catch a walker that would swallow the next tag as payload. The reserved-range edges (0x9/0xA, 0xD/0xE, 0x06/0x07, 0x7F) catch off-by-one range decoding. Bytes sent after the end item, and a stall in the middle of a payload, expose a walker that keeps running past `done` or loses its count while idle.

// File: rtl/rdw_pkg.sv
package rdw_pkg;

   typedef enum logic [1:0] {
      ST_TAG  = 2'd0,
      ST_LEN  = 2'd1,
      ST_PAY  = 2'd2,
      ST_DONE = 2'd3
   } rdw_state_e;

   localparam int unsigned BYTE_W       = 8;
   localparam int unsigned SMALL_NUM_W  = 4;
   localparam int unsigned SMALL_LEN_W  = 3;
   localparam int unsigned LARGE_NUM_W  = 7;

   typedef struct packed {
      logic                   is_large;
      logic [LARGE_NUM_W-1:0] item;
      logic [SMALL_LEN_W-1:0] small_len;
      logic                   is_end;
      logic                   is_rsvd;
   } rdw_tag_t;

endpackage

// File: rtl/rdw_tag_decode.sv
module rdw_tag_decode
   import rdw_pkg::*;
#(
   parameter logic [SMALL_NUM_W-1:0] END_NUM        = 4'hF,
   parameter logic [SMALL_NUM_W-1:0] SMALL_RSVD_LO  = 4'hA,
   parameter logic [SMALL_NUM_W-1:0] SMALL_RSVD_HI  = 4'hD,
   parameter logic [LARGE_NUM_W-1:0] LARGE_RSVD_LO  = 7'h07
) (
   input  logic [BYTE_W-1:0] tag_byte,
   output rdw_tag_t          info
);

   logic [SMALL_NUM_W-1:0] small_num;
   logic [LARGE_NUM_W-1:0] large_num;
   logic                   small_rsvd;
   logic                   large_rsvd;

   assign small_num  = tag_byte[6:3];
   assign large_num  = tag_byte[6:0];
   assign small_rsvd = (small_num >= SMALL_RSVD_LO) && (small_num <= SMALL_RSVD_HI);
   assign large_rsvd = (large_num >= LARGE_RSVD_LO);

   always_comb begin
      info.is_large  = tag_byte[7];
      info.small_len = tag_byte[2:0];
      if (tag_byte[7]) begin
         info.item    = large_num;
         info.is_end  = 1'b0;
         info.is_rsvd = large_rsvd;
      end else begin
         info.item    = {{(LARGE_NUM_W-SMALL_NUM_W){1'b0}}, small_num};
         info.is_end  = (small_num == END_NUM);
         info.is_rsvd = small_rsvd;
      end
   end

endmodule

// File: rtl/rdw_len_capture.sv
module rdw_len_capture
   import rdw_pkg::*;
#(
   parameter int unsigned LEN_BYTES = 2,
   localparam int unsigned LEN_W    = LEN_BYTES * BYTE_W,
   localparam int unsigned IDX_W    = (LEN_BYTES > 1) ? $clog2(LEN_BYTES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [IDX_W-1:0]  idx,
   input  logic [BYTE_W-1:0] data,
   output logic [LEN_W-1:0]  len_now
);

   for (genvar g = 0; g < LEN_BYTES; g++) begin : g_lane
      logic [BYTE_W-1:0] lane_q;
      logic              hit;

      assign hit = wr && (idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lane_q <= '0;
         end else if (hit) begin
            lane_q <= data;
         end
      end

      assign len_now[g*BYTE_W +: BYTE_W] = hit ? data : lane_q;
   end

endmodule

// File: rtl/rdw_len_counter.sv
module rdw_len_counter #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         last
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (dec) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign last = (cnt_q == W'(1));

   // R4: a payload byte is only consumed while bytes remain
   assert_cnt_no_underflow_R4: assert property (
      @(posedge clk) disable iff (!rst_n)
      (dec && !clr && !load) |-> (cnt_q != '0));

endmodule

// File: rtl/rdesc_walker.sv
module rdesc_walker
   import rdw_pkg::*;
#(
   parameter int unsigned LEN_BYTES = 2,
   localparam int unsigned LEN_W    = LEN_BYTES * BYTE_W,
   localparam int unsigned IDX_W    = (LEN_BYTES > 1) ? $clog2(LEN_BYTES) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic                   in_valid,
   input  logic [BYTE_W-1:0]      in_data,
   output logic                   in_ready,
   output logic                   hdr_valid,
   output logic                   hdr_large,
   output logic [LARGE_NUM_W-1:0] hdr_item,
   output logic [LEN_W-1:0]       hdr_len,
   output logic                   pay_valid,
   output logic [BYTE_W-1:0]      pay_data,
   output logic                   done,
   output logic                   reserved_seen
);

   rdw_state_e             state_q, state_d;
   rdw_tag_t               tag;
   logic                   accept;
   logic [LARGE_NUM_W-1:0] big_item_q;
   logic                   big_rsvd_q;
   logic [IDX_W-1:0]       idx_q, idx_d;
   logic                   len_wr;
   logic [LEN_W-1:0]       len_now;
   logic                   cnt_load, cnt_dec, cnt_last;
   logic [LEN_W-1:0]       cnt_val;
   logic                   emit, emit_large, emit_rsvd, pay_emit;
   logic [LARGE_NUM_W-1:0] emit_item;
   logic [LEN_W-1:0]       emit_len;
   logic                   latch_big;
   logic                   rsvd_q;

   assign in_ready = !start;
   assign accept   = in_valid && in_ready;

   rdw_tag_decode u_dec (
      .tag_byte (in_data),
      .info     (tag)
   );

   rdw_len_capture #(.LEN_BYTES(LEN_BYTES)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (len_wr),
      .idx     (idx_q),
      .data    (in_data),
      .len_now (len_now)
   );

   rdw_len_counter #(.W(LEN_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (start),
      .load     (cnt_load),
      .load_val (cnt_val),
      .dec      (cnt_dec),
      .last     (cnt_last)
   );

   always_comb begin
      state_d    = state_q;
      idx_d      = idx_q;
      len_wr     = 1'b0;
      cnt_load   = 1'b0;
      cnt_dec    = 1'b0;
      cnt_val    = '0;
      emit       = 1'b0;
      emit_large = 1'b0;
      emit_rsvd  = 1'b0;
      emit_item  = '0;
      emit_len   = '0;
      pay_emit   = 1'b0;
      latch_big  = 1'b0;
      if (start) begin
         state_d = ST_TAG;
         idx_d   = '0;
      end else if (accept) begin
         unique case (state_q)
            ST_TAG: begin
               if (tag.is_large) begin
                  latch_big = 1'b1;
                  idx_d     = '0;
                  state_d   = ST_LEN;
               end else begin
                  emit      = 1'b1;
                  emit_item = tag.item;
                  emit_rsvd = tag.is_rsvd;
                  emit_len  = {{(LEN_W-SMALL_LEN_W){1'b0}}, tag.small_len};
                  if (tag.is_end) begin
                     state_d = ST_DONE;
                  end else if (tag.small_len != '0) begin
                     cnt_load = 1'b1;
                     cnt_val  = emit_len;
                     state_d  = ST_PAY;
                  end
               end
            end
            ST_LEN: begin
               len_wr = 1'b1;
               if (idx_q == IDX_W'(LEN_BYTES-1)) begin
                  emit       = 1'b1;
                  emit_large = 1'b1;
                  emit_item  = big_item_q;
                  emit_rsvd  = big_rsvd_q;
                  emit_len   = len_now;
                  idx_d      = '0;
                  if (len_now != '0) begin
                     cnt_load = 1'b1;
                     cnt_val  = len_now;
                     state_d  = ST_PAY;
                  end else begin
                     state_d  = ST_TAG;
                  end
               end else begin
                  idx_d = idx_q + 1'b1;
               end
            end
            ST_PAY: begin
               pay_emit = 1'b1;
               cnt_dec  = 1'b1;
               if (cnt_last) begin
                  state_d = ST_TAG;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_TAG;
         idx_q      <= '0;
         big_item_q <= '0;
         big_rsvd_q <= 1'b0;
      end else begin
         state_q <= state_d;
         idx_q   <= idx_d;
         if (latch_big) begin
            big_item_q <= tag.item;
            big_rsvd_q <= tag.is_rsvd;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hdr_valid <= 1'b0;
         hdr_large <= 1'b0;
         hdr_item  <= '0;
         hdr_len   <= '0;
         pay_valid <= 1'b0;
         pay_data  <= '0;
         rsvd_q    <= 1'b0;
      end else begin
         hdr_valid <= emit;
         pay_valid <= pay_emit;
         if (emit) begin
            hdr_large <= emit_large;
            hdr_item  <= emit_item;
            hdr_len   <= emit_len;
         end
         if (pay_emit) begin
            pay_data <= in_data;
         end
         if (start) begin
            rsvd_q <= 1'b0;
         end else if (emit && emit_rsvd) begin
            rsvd_q <= 1'b1;
         end
      end
   end

   assign done          = (state_q == ST_DONE);
   assign reserved_seen = rsvd_q;

   // R4: header and payload strobes never coincide
   assert_hdr_pay_excl_R4: assert property (
      @(posedge clk) disable iff (!rst_n)
      !(hdr_valid && pay_valid));

   // R2: small headers carry at most a 3-bit length
   assert_small_len_R2: assert property (
      @(posedge clk) disable iff (!rst_n)
      (hdr_valid && !hdr_large) |-> (hdr_len < LEN_W'(8)));

   // R6: an end item header coincides with done
   assert_end_done_R6: assert property (
      @(posedge clk) disable iff (!rst_n)
      (hdr_valid && !hdr_large && hdr_item == 7'h0F) |-> done);

   // R7: no events once done has been held
   assert_done_quiet_R7: assert property (
      @(posedge clk) disable iff (!rst_n)
      (done && $past(done)) |-> (!hdr_valid && !pay_valid));

   // R8: start clears the end and reserved flags
   assert_start_clears_R8: assert property (
      @(posedge clk) disable iff (!rst_n)
      start |=> (!done && !reserved_seen));

   // R9: reserved flag is sticky until start
   assert_rsvd_sticky_R9: assert property (
      @(posedge clk) disable iff (!rst_n)
      (reserved_seen && !start) |=> reserved_seen);

endmodule

// File: tb/tb_rdesc_walker.sv
`timescale 1ns/1ps
module tb_rdesc_walker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = '0;
   logic        in_ready;
   logic        hdr_valid;
   logic        hdr_large;
   logic [6:0]  hdr_item;
   logic [15:0] hdr_len;
   logic        pay_valid;
   logic [7:0]  pay_data;
   logic        done;
   logic        reserved_seen;

   int n_tests = 0;
   int n_fail  = 0;
   int cycles  = 0;

   always #5 clk = ~clk;

   rdesc_walker dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .hdr_valid(hdr_valid), .hdr_large(hdr_large), .hdr_item(hdr_item),
      .hdr_len(hdr_len), .pay_valid(pay_valid), .pay_data(pay_data),
      .done(done), .reserved_seen(reserved_seen)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = b;
      @(posedge clk);
      #1;
      in_valid = 1'b0;
   endtask

   task automatic pulse_start();
      @(negedge clk);
      start = 1'b1;
      #1;
      chk("R8 in_ready low in start cycle", 32'(in_ready), 0);
      @(posedge clk);
      #1;
      start = 1'b0;
      chk("R8 done cleared", 32'(done), 0);
      chk("R8 reserved cleared", 32'(reserved_seen), 0);
   endtask

   task automatic chk_hdr(input string req, input logic lg, input logic [6:0] item,
                          input logic [15:0] len);
      chk({req, " hdr_valid"}, 32'(hdr_valid), 1);
      chk({req, " hdr_large"}, 32'(hdr_large), 32'(lg));
      chk({req, " hdr_item"}, 32'(hdr_item), 32'(item));
      chk({req, " hdr_len"}, 32'(hdr_len), 32'(len));
      chk({req, " no payload"}, 32'(pay_valid), 0);
   endtask

   task automatic chk_pay(input string req, input logic [7:0] d);
      chk({req, " pay_valid"}, 32'(pay_valid), 1);
      chk({req, " pay_data"}, 32'(pay_data), 32'(d));
      chk({req, " no header"}, 32'(hdr_valid), 0);
   endtask

   task automatic t_reset();
      chk("R1 done", 32'(done), 0);
      chk("R1 hdr_valid", 32'(hdr_valid), 0);
      chk("R1 pay_valid", 32'(pay_valid), 0);
      chk("R1 reserved_seen", 32'(reserved_seen), 0);
      chk("R1 in_ready", 32'(in_ready), 1);
   endtask

   task automatic t_small();
      send(8'h23);                       // item 4, len 3
      chk_hdr("R2 small", 1'b0, 7'h4, 16'd3);
      send(8'h11); chk_pay("R4 small p0", 8'h11);
      send(8'h22); chk_pay("R4 small p1", 8'h22);
      send(8'h33); chk_pay("R4 small p2", 8'h33);
      send(8'h10);                       // item 2, len 0
      chk_hdr("R5 small zero", 1'b0, 7'h2, 16'd0);
      send(8'h38);                       // item 7, len 0, right after
      chk_hdr("R5 tag after zero", 1'b0, 7'h7, 16'd0);
      chk("R9 not reserved yet", 32'(reserved_seen), 0);
   endtask

   task automatic t_large();
      send(8'h81);
      chk("R3 no hdr after tag", 32'(hdr_valid), 0);
      send(8'h02);
      chk("R3 no hdr after low", 32'(hdr_valid), 0);
      send(8'h00);
      chk_hdr("R3 large", 1'b1, 7'h01, 16'd2);
      send(8'hAA); chk_pay("R4 large p0", 8'hAA);
      send(8'hBB); chk_pay("R4 large p1", 8'hBB);
      send(8'h09);                       // small item 1 len 1
      chk_hdr("R4 tag after large", 1'b0, 7'h1, 16'd1);
      send(8'h5C); chk_pay("R4 small after large", 8'h5C);
      // 256-byte payload exercises the high length byte
      send(8'h84); send(8'h00); send(8'h01);
      chk_hdr("R3 large 256", 1'b1, 7'h04, 16'd256);
      begin
         int good = 0;
         for (int i = 0; i < 256; i++) begin
            send(8'(i));
            if (pay_valid === 1'b1 && pay_data === 8'(i) && hdr_valid === 1'b0) good++;
         end
         chk("R4 256 payload bytes", 32'(good), 256);
      end
      send(8'h18);                       // item 3 len 0
      chk_hdr("R4 tag after 256", 1'b0, 7'h3, 16'd0);
      send(8'h82); send(8'h00); send(8'h00);
      chk_hdr("R5 large zero", 1'b1, 7'h02, 16'd0);
      send(8'h23);
      chk_hdr("R5 tag after large zero", 1'b0, 7'h4, 16'd3);
      // stall mid payload
      send(8'h71);
      chk_pay("R4 p0 before stall", 8'h71);
      repeat (5) @(posedge clk);
      #1;
      chk("R10 idle no pay", 32'(pay_valid), 0);
      chk("R10 idle no hdr", 32'(hdr_valid), 0);
      send(8'h72); chk_pay("R10 p1 after stall", 8'h72);
      send(8'h73); chk_pay("R10 p2 after stall", 8'h73);
      send(8'h30);                       // item 6 len 0
      chk_hdr("R10 tag after stall", 1'b0, 7'h6, 16'd0);
      chk("R9 large 1..6 not reserved", 32'(reserved_seen), 0);
   endtask

   task automatic t_reserved();
      send(8'h48);                       // item 9 len 0
      chk_hdr("R9 item 9", 1'b0, 7'h9, 16'd0);
      chk("R9 item 9 not reserved", 32'(reserved_seen), 0);
      send(8'h70);                       // item E len 0
      chk("R9 item E not reserved", 32'(reserved_seen), 0);
      send(8'h51);                       // item A len 1
      chk_hdr("R9 item A", 1'b0, 7'hA, 16'd1);
      chk("R9 item A reserved", 32'(reserved_seen), 1);
      send(8'h5A); chk_pay("R9 reserved payload", 8'h5A);
      send(8'h10);
      chk("R9 sticky", 32'(reserved_seen), 1);
      pulse_start();
      send(8'h68);                       // item D len 0
      chk("R9 item D reserved", 32'(reserved_seen), 1);
      pulse_start();
      send(8'h86); send(8'h00); send(8'h00);
      chk("R9 large 06 not reserved", 32'(reserved_seen), 0);
      send(8'h87); send(8'h01); send(8'h00);
      chk_hdr("R9 large 07", 1'b1, 7'h07, 16'd1);
      chk("R9 large 07 reserved", 32'(reserved_seen), 1);
      send(8'hE7); chk_pay("R9 large reserved payload", 8'hE7);
      pulse_start();
      send(8'hFF); send(8'h00); send(8'h00);
      chk("R9 large 7F reserved", 32'(reserved_seen), 1);
      pulse_start();
   endtask

   task automatic t_end();
      send(8'h23);
      send(8'h01);                       // payload then start mid-item
      pulse_start();
      send(8'h79);                       // end item len 1
      chk_hdr("R6 end", 1'b0, 7'hF, 16'd1);
      chk("R6 done", 32'(done), 1);
      send(8'h23);
      chk("R7 no hdr", 32'(hdr_valid), 0);
      chk("R7 no pay", 32'(pay_valid), 0);
      send(8'h81);
      chk("R7 no hdr 2", 32'(hdr_valid), 0);
      chk("R7 done held", 32'(done), 1);
      pulse_start();
      send(8'h23);
      chk_hdr("R8 walks after restart", 1'b0, 7'h4, 16'd3);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_small();
      t_large();
      t_reserved();
      t_end();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule